// File: doc/BRIEF.md
# Tick Compare Timer with Soft Interrupts

This block keeps a free-running tick counter and three compare registers. Each compare register can raise a timer interrupt when the counter reaches it. The first compare register watches the tick count. The second watches the system tick, and the third is the hypervisor copy that also watches the system tick. Here the system tick is the same counter as the tick, so all three compare registers test one count.

Each compare register has two parts. Its top bit masks the interrupt. Its lower bits hold the target value. Writing a compare register drops any match that is waiting on it. The block then decides again whether to wait for a match. It waits only when the interrupt is unmasked and the target is strictly ahead of the count at the time of the write.

When a waiting match is hit, the block does three things. It sets a bit in the soft-interrupt register or the hypervisor-interrupt register. It pulses a one-cycle recheck signal. It stops waiting until the next compare write.

Software can change the soft-interrupt register in three ways: a direct write, a set alias and a clear alias. Every one of these writes also pulses the recheck signal. Registers are reached through one write port and one combinational read port.

Top module: `tick_cmp_timer`

Addresses and their encodings:

| addr | Register |
|------|----------|
| 0 | counter |
| 1 | tick compare |
| 2 | system compare |
| 3 | hypervisor compare |
| 4 | soft-interrupt direct |
| 5 | soft-interrupt set alias |
| 6 | soft-interrupt clear alias |
| 7 | hypervisor-interrupt flag |

## Requirements
- R1: After reset, `softint`, `hintp` and `recheck` are 0. Each compare register reads `{1'b1, 63'b0}`, which means masked with a target of zero.
- R2: The counter is read and written at addr 0 as `{flag, count[62:0]}`. A write loads both fields. In every other cycle the count grows by exactly one.
- R3: A direct write (addr 4) stores `wr_data[SI_W-1:0]` into `softint`. The new value shows the cycle after the write, and `recheck` is 1 in that cycle only. Reads at addr 4 to 6 return `softint` zero-extended.
- R4: A write to the set alias (addr 5) ORs `wr_data[SI_W-1:0]` into `softint`. It also pulses `recheck`.
- R5: A write to the clear alias (addr 6) clears every `softint` bit whose `wr_data` bit is 1. It also pulses `recheck`.
- R6: Writing a compare register with bit 63 set never produces a match. A compare register reads back the full value last written to it.
- R7: Writing a compare register with a target not greater than the count at the write cycle does not arm a match. This holds even if the counter is later reloaded so that it reaches that target.
- R8: An armed tick compare fires in the cycle the count equals its target. In the next cycle `softint[0]` is 1 and `recheck` is 1 for exactly one cycle. The compare does not fire again.
- R9: A match of the system compare sets `softint[16]`. A match of the hypervisor compare sets `hintp`. Both test the same counter as the tick compare. `hintp` can be written directly at addr 7 through `wr_data[0]`.
- R10: Rewriting an armed compare register cancels its earlier target. Only the new target, if it is armed, can fire.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address, for both write and read |
| wr_data | input | W | Write data |
| rd_data | output | W | Combinational read data for `addr` |
| softint | output | SI_W | Soft-interrupt request bits |
| hintp | output | 1 | Hypervisor timer interrupt request |
| recheck | output | 1 | One-cycle pulse asking the core to re-examine interrupts |

## Verification
Suppose an armed flag is left set after a cancelling write, or after a write whose target is behind the count. The port would then show a spurious `softint` or `hintp` bit, plus a `recheck` pulse. This appears one cycle after the count reaches the stale target. The bench makes this visible by reloading the counter so that it crosses the stale value within a few cycles.

A wrong count shows at once in an addr 0 read. It also shifts every later interrupt by the same number of cycles. The expected interrupt cycle is predicted exactly, so one cycle of skew is caught.

// File: rtl/tick_cmp_timer.sv
module tick_cmp_timer #(
  parameter int W    = 64,
  parameter int SI_W = 17
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [2:0]      addr,
  input  logic [W-1:0]    wr_data,
  output logic [W-1:0]    rd_data,
  output logic [SI_W-1:0] softint,
  output logic            hintp,
  output logic            recheck
);
  localparam int CW      = W - 1;
  localparam int STK_BIT = 16;
  localparam logic [2:0] A_CNT  = 3'd0;
  localparam logic [2:0] A_SOFT = 3'd4;
  localparam logic [2:0] A_SSET = 3'd5;
  localparam logic [2:0] A_SCLR = 3'd6;
  localparam logic [2:0] A_HINT = 3'd7;

  logic [CW-1:0]       cnt;
  logic                npt;
  logic [2:0]          armed, fire;
  logic [2:0][W-1:0]   cmp_v;
  logic [SI_W-1:0]     soft_nx;
  logic                soft_wr;

  assign soft_wr = wr_en && (addr == A_SOFT || addr == A_SSET || addr == A_SCLR);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= '0;
      npt <= 1'b0;
    end else if (wr_en && addr == A_CNT) begin
      cnt <= wr_data[CW-1:0];
      npt <= wr_data[W-1];
    end else begin
      cnt <= cnt + 1'b1;
    end

  for (genvar i = 0; i < 3; i++) begin : g_cmp
    logic [W-1:0] cmp_q;
    logic         arm_q;
    logic         wr_me;
    assign wr_me    = wr_en && (addr == 3'(i + 1));
    assign fire[i]  = arm_q && !wr_me && (cnt == cmp_q[CW-1:0]);
    assign armed[i] = arm_q;
    assign cmp_v[i] = cmp_q;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cmp_q <= {1'b1, {CW{1'b0}}};
        arm_q <= 1'b0;
      end else if (wr_me) begin
        cmp_q <= wr_data;
        arm_q <= !wr_data[W-1] && (wr_data[CW-1:0] > cnt);
      end else if (fire[i]) begin
        arm_q <= 1'b0;
      end
  end

  always_comb begin
    soft_nx = softint;
    if (wr_en)
      case (addr)
        A_SOFT:  soft_nx = wr_data[SI_W-1:0];
        A_SSET:  soft_nx = softint | wr_data[SI_W-1:0];
        A_SCLR:  soft_nx = softint & ~wr_data[SI_W-1:0];
        default: soft_nx = softint;
      endcase
    soft_nx[0]       = soft_nx[0] | fire[0];
    soft_nx[STK_BIT] = soft_nx[STK_BIT] | fire[1];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      softint <= '0;
      hintp   <= 1'b0;
      recheck <= 1'b0;
    end else begin
      softint <= soft_nx;
      hintp   <= ((wr_en && addr == A_HINT) ? wr_data[0] : hintp) | fire[2];
      recheck <= soft_wr | (|fire);
    end

  always_comb
    case (addr)
      A_CNT:                  rd_data = {npt, cnt};
      3'd1:                   rd_data = cmp_v[0];
      3'd2:                   rd_data = cmp_v[1];
      3'd3:                   rd_data = cmp_v[2];
      A_SOFT, A_SSET, A_SCLR: rd_data = W'(softint);
      default:                rd_data = W'(hintp);
    endcase
endmodule

// File: rtl/tick_cmp_timer_chk.sv
module tick_cmp_timer_chk #(
  parameter int W    = 64,
  parameter int SI_W = 17
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [2:0]      addr,
  input logic [W-1:0]    wr_data,
  input logic [SI_W-1:0] softint,
  input logic            hintp,
  input logic            recheck,
  input logic [W-2:0]    cnt,
  input logic [2:0]      armed,
  input logic [2:0]      fire
);
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == 3'd0) |=> cnt == $past(cnt) + 1'b1); // R2
  AST_SOFT_RECHECK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == 3'd4 || addr == 3'd5 || addr == 3'd6)) |=> recheck); // R3
  AST_SET_ORS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd5) |=> (softint & $past(wr_data[SI_W-1:0])) == $past(wr_data[SI_W-1:0])); // R4
  AST_CLR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd6 && fire == 3'b000) |=> (softint & $past(wr_data[SI_W-1:0])) == '0); // R5
  AST_MASKED_NO_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd1 && wr_data[W-1]) |=> !armed[0]); // R6
  AST_BEHIND_NO_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd1 && wr_data[W-2:0] <= cnt) |=> !armed[0]); // R7
  AST_TICK_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    fire[0] |=> softint[0] && recheck && !armed[0]); // R8
  AST_STK_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    fire[1] |=> softint[16] && recheck); // R9
  AST_HSTK_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    fire[2] |=> hintp && recheck); // R9
endmodule

bind tick_cmp_timer tick_cmp_timer_chk #(.W(W), .SI_W(SI_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .softint(softint), .hintp(hintp), .recheck(recheck),
  .cnt(cnt), .armed(armed), .fire(fire)
);

// File: tb/test_tick_cmp_timer.sv
`timescale 1ns/1ps
module test_tick_cmp_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd_data;
  logic [16:0] softint;
  logic        hintp, recheck;

  tick_cmp_timer i_tick_cmp_timer (.*);

  always #4 clk = ~clk;

  typedef struct {
    int          cyc;
    int          kind;
    logic [63:0] val;
    string       tag;
  } exp_t;
  exp_t q[$];

  int          cyc = 0;
  int          errors = 0;
  int          checks = 0;
  logic [62:0] base = '0;
  int          bcyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [62:0] cnt_at(int c);
    return base + 63'(c - bcyc);
  endfunction

  task automatic push(int c, int kind, logic [63:0] v, string tag);
    exp_t e;
    e.cyc = c; e.kind = kind; e.val = v; e.tag = tag;
    q.push_back(e);
  endtask

  always begin
    @(negedge clk);
    #2;
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].cyc == cyc) begin
        logic [63:0] act;
        case (q[i].kind)
          0: act = 64'(softint);
          1: act = 64'(hintp);
          2: act = 64'(recheck);
          default: act = rd_data;
        endcase
        checks++;
        if (act !== q[i].val) begin
          errors++;
          $display("FAIL %s kind=%0d cycle=%0d actual=%h expected=%h",
                   q[i].tag, q[i].kind, cyc, act, q[i].val);
        end
        q.delete(i);
      end
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic wr(logic [2:0] a, logic [63:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(logic [2:0] a, logic [63:0] v, string tag);
    addr = a;
    push(cyc, 3, v, tag);
    tick();
  endtask

  task automatic soft_op(logic [2:0] a, logic [63:0] d, logic [16:0] v, string tag);
    int k;
    k = cyc;
    wr(a, d);
    push(k + 1, 0, 64'(v), tag);
    push(k + 1, 2, 64'd1, tag);
    push(k + 2, 2, 64'd0, tag);
    tick(); tick();
  endtask

  initial begin
    #1_600_000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int k, k2;
    logic [62:0] v, v1, v2;
    repeat (3) tick();
    rst_n = 1'b1;
    push(cyc, 0, 64'd0, "R1 softint");
    push(cyc, 1, 64'd0, "R1 hintp");
    push(cyc, 2, 64'd0, "R1 recheck");
    rd_chk(3'd1, 64'h8000_0000_0000_0000, "R1 tick cmp");
    rd_chk(3'd3, 64'h8000_0000_0000_0000, "R1 hyp cmp");

    k = cyc;
    wr(3'd0, {1'b1, 63'h100});
    base = 63'h100; bcyc = k + 1;
    repeat (3) tick();
    rd_chk(3'd0, {1'b1, cnt_at(cyc)}, "R2 count a");
    repeat (5) tick();
    rd_chk(3'd0, {1'b1, cnt_at(cyc)}, "R2 count b");

    soft_op(3'd4, 64'hFFFF_0000_0001_2345, 17'h12345, "R3 direct");
    rd_chk(3'd4, 64'h12345, "R3 read");
    soft_op(3'd5, 64'h0C0, 17'h123C5, "R4 set");
    soft_op(3'd6, 64'h10005, 17'h023C0, "R5 clear");
    soft_op(3'd4, 64'd0, 17'h0, "R3 zero");

    k = cyc; v = cnt_at(k) + 63'd10;
    wr(3'd1, {1'b0, v});
    push(k + 10, 0, 64'd0, "R8 before");
    push(k + 10, 2, 64'd0, "R8 before");
    push(k + 11, 0, 64'd1, "R8 fire");
    push(k + 11, 2, 64'd1, "R8 pulse");
    push(k + 12, 2, 64'd0, "R8 pulse end");
    push(k + 15, 2, 64'd0, "R8 once");
    push(k + 20, 0, 64'd1, "R8 held");
    repeat (22) tick();
    rd_chk(3'd1, {1'b0, v}, "R6 readback");
    soft_op(3'd6, '1, 17'h0, "R5 clear all");

    k = cyc; v = cnt_at(k) + 63'd6;
    wr(3'd2, {1'b0, v});
    push(k + 6, 0, 64'd0, "R9 sys before");
    push(k + 7, 0, 64'h10000, "R9 sys fire");
    repeat (10) tick();
    soft_op(3'd6, 64'h10000, 17'h0, "R5 clear sys");
    k = cyc; v = cnt_at(k) + 63'd5;
    wr(3'd3, {1'b0, v});
    push(k + 5, 1, 64'd0, "R9 hyp before");
    push(k + 6, 1, 64'd1, "R9 hyp fire");
    push(k + 6, 2, 64'd1, "R9 hyp pulse");
    repeat (10) tick();
    k = cyc;
    wr(3'd7, 64'd0);
    push(k + 1, 1, 64'd0, "R9 hint write");
    tick();

    k = cyc; v = cnt_at(k) + 63'd4;
    wr(3'd1, {1'b1, v});
    push(k + 5, 0, 64'd0, "R6 masked");
    push(k + 5, 2, 64'd0, "R6 masked");
    push(k + 6, 2, 64'd0, "R6 masked");
    repeat (10) tick();

    k = cyc; v = cnt_at(k);
    wr(3'd1, {1'b0, v});
    k2 = cyc;
    wr(3'd0, {1'b0, v - 63'd3});
    base = v - 63'd3; bcyc = k2 + 1;
    push(k2 + 5, 0, 64'd0, "R7 equal");
    push(k2 + 5, 2, 64'd0, "R7 equal");
    push(k2 + 6, 2, 64'd0, "R7 equal");
    repeat (10) tick();

    k = cyc; v1 = cnt_at(k) + 63'd8;
    wr(3'd1, {1'b0, v1});
    tick();
    k2 = cyc; v2 = cnt_at(k2) + 63'd12;
    wr(3'd1, {1'b0, v2});
    push(k + 9, 0, 64'd0, "R10 cancelled");
    push(k + 9, 2, 64'd0, "R10 cancelled");
    push(k + 10, 0, 64'd0, "R10 cancelled");
    push(k2 + 13, 0, 64'd1, "R10 new fire");
    push(k2 + 13, 2, 64'd1, "R10 new pulse");
    repeat (20) tick();

    repeat (3) tick();
    if (q.size() != 0) begin
      errors += q.size(); checks += q.size();
      $display("FAIL unchecked items actual=%0d expected=0", q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule